// File: doc/BRIEF.md
# Seeded Three-Bomb Mask Placer

The block turns a 15-bit seed into a 16-cell bomb mask holding three bombs. Each bomb takes a 5-bit slice of the seed. The slice gives a start cell and a length of one or two cells. Bombs are placed in a fixed order. Each new bomb is tested against the bombs already placed, widened by one cell on each side. A candidate that touches this guard band moves up one cell, wrapping at the top of the field, and is tested again until it fits.

Work is sequential, with one candidate test per clock. A start pulse in the idle state captures the seed and clears the mask. A one-cycle done pulse marks the cycle in which the final mask first appears. The mask then holds until the next start. The cell count, bomb count and gap width are parameters. The defaults give 16 cells, 3 bombs and a 1-cell gap.

Top module: `bomb_placer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mask_o` is all zero and `done_o` is low.
- R2: Bomb k is decoded from `seed_i[5k+4:5k]`. Bits [3:0] give the start cell and bit 4 gives the length (0 means one cell, 1 means two). A two-cell bomb covers its start cell and the cell one higher, and cell 15 wraps to cell 0.
- R3: When `start_i` is seen high in the idle state, the seed is captured and the mask is cleared at that clock edge. The first candidate is tested at the next edge.
- R4: A candidate collides when any of its cells is placed, or is next to a placed cell on a ring of 16 cells. A colliding candidate's start cell moves up by one, wrapping from 15 to 0. Exactly one test is made per clock.
- R5: Bombs are committed in the order 0, 1, 2. While a run is active, the mask only gains cells.
- R6: `done_o` is high for exactly one cycle, the cycle after the edge that commits bomb 2, and the final mask is visible in that cycle.
- R7: A start pulse while a run is active is ignored. The run finishes with the mask that its own seed gives.
- R8: No three adjacent cells of the mask are set, because bombs never touch.
- R9: `done_o` is raised no later than BOMBS×CELLS cycles after the start edge.
- R10: When no run is active and `start_i` is low, `mask_o` does not change, whatever `seed_i` does.
- R11: A seed whose bombs never collide completes in 3 tests, so `done_o` is high in the fourth cycle after the start cycle.
- R12: When `done_o` is high, the mask holds between BOMBS and 2×BOMBS set cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a placement run when idle |
| seed_i | input | 15 | Three 5-bit bomb slices, bomb 0 in the low bits |
| mask_o | output | 16 | Placed bombs, 1 marks a bomb cell |
| done_o | output | 1 | One-cycle pulse when the final mask is ready |

## Verification
The checker watches invariants on every cycle. The done pulse lasts one cycle and occurs only in idle. The mask only grows during a run and stays frozen in idle. No three adjacent cells are ever set. The bomb count is within bounds at done, and a counter enforces the latency bound. Only the bench's scenarios can show the exact cells each seed produces, the cycle count of each collision walk, the wrap of a two-cell bomb from cell 15 to cell 0, and that a start pulse during a run has no effect. They do this by comparing against a behavioural model on every clock and against hand-computed masks.

// File: rtl/bomb_place_pkg.sv
package bomb_place_pkg;
   typedef enum logic {
      PL_IDLE = 1'b0,
      PL_TEST = 1'b1
   } place_state_e;
endpackage

// File: rtl/bp_cand_decode.sv
module bp_cand_decode #(
   parameter int unsigned CELLS = 16,
   parameter int unsigned POS_W = $clog2(CELLS)
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic             long_i,
   output logic [CELLS-1:0] cells_o
);
   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      localparam int unsigned PREV = (c + CELLS - 1) % CELLS;
      assign cells_o[c] = (pos_i == POS_W'(c)) |
                          (long_i & (pos_i == POS_W'(PREV)));
   end
endmodule

// File: rtl/bp_guard_band.sv
module bp_guard_band #(
   parameter int unsigned CELLS = 16,
   parameter int unsigned GAP   = 1
) (
   input  logic [CELLS-1:0] placed_i,
   output logic [CELLS-1:0] band_o
);
   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      logic [2*GAP:0] taps;
      assign taps[GAP] = placed_i[c];
      for (genvar d = 1; d <= GAP; d++) begin : g_dist
         assign taps[GAP+d] = placed_i[(c + d) % CELLS];
         assign taps[GAP-d] = placed_i[(c + CELLS - d) % CELLS];
      end
      assign band_o[c] = |taps;
   end
endmodule

// File: rtl/bp_field_sel.sv
module bp_field_sel #(
   parameter int unsigned BOMBS   = 3,
   parameter int unsigned FIELD_W = 5,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [BOMBS*FIELD_W-1:0] seed_i,
   input  logic [IDX_W-1:0]         idx_i,
   output logic [FIELD_W-1:0]       field_o
);
   logic [FIELD_W-1:0] slices [BOMBS];

   for (genvar k = 0; k < BOMBS; k++) begin : g_slice
      assign slices[k] = seed_i[k*FIELD_W +: FIELD_W];
   end

   always_comb begin
      field_o = '0;
      for (int k = 0; k < BOMBS; k++) begin
         if (idx_i == IDX_W'(k)) field_o = slices[k];
      end
   end
endmodule

// File: rtl/bomb_placer.sv
module bomb_placer
   import bomb_place_pkg::*;
#(
   parameter int unsigned CELLS = 16,
   parameter int unsigned BOMBS = 3,
   parameter int unsigned GAP   = 1,
   localparam int unsigned POS_W   = $clog2(CELLS),
   localparam int unsigned FIELD_W = POS_W + 1,
   localparam int unsigned SEED_W  = BOMBS * FIELD_W,
   localparam int unsigned IDX_W   = (BOMBS > 1) ? $clog2(BOMBS + 1) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [SEED_W-1:0] seed_i,
   output logic [CELLS-1:0]  mask_o,
   output logic              done_o
);
   if (CELLS != (1 << POS_W)) begin : g_bad_cells
      $error("bomb_placer: CELLS must be a power of two");
   end
   if (BOMBS < 1) begin : g_bad_bombs
      $error("bomb_placer: BOMBS must be at least one");
   end
   if ((2 + 2 * GAP) * BOMBS > CELLS) begin : g_bad_fit
      $error("bomb_placer: bombs with gaps may not fit in CELLS");
   end

   place_state_e       state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   idx_inc;
   logic [SEED_W-1:0]  seed_q;
   logic [POS_W-1:0]   pos_q;
   logic               long_q;
   logic [CELLS-1:0]   placed_q;
   logic [CELLS-1:0]   cand;
   logic [CELLS-1:0]   band;
   logic [FIELD_W-1:0] nxt_field;
   logic               fits;
   logic               last;
   logic               done_q;
   logic               busy;

   bp_cand_decode #(.CELLS(CELLS), .POS_W(POS_W)) u_decode (
      .pos_i  (pos_q),
      .long_i (long_q),
      .cells_o(cand)
   );

   bp_guard_band #(.CELLS(CELLS), .GAP(GAP)) u_band (
      .placed_i(placed_q),
      .band_o  (band)
   );

   bp_field_sel #(.BOMBS(BOMBS), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_sel (
      .seed_i (seed_q),
      .idx_i  (idx_inc),
      .field_o(nxt_field)
   );

   assign idx_inc = idx_q + IDX_W'(1);
   assign last    = (idx_q == IDX_W'(BOMBS - 1));
   assign fits    = ~|(cand & band);
   assign busy    = (state_q == PL_TEST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= PL_IDLE;
         idx_q    <= '0;
         seed_q   <= '0;
         pos_q    <= '0;
         long_q   <= 1'b0;
         placed_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            PL_IDLE: begin
               if (start_i) begin
                  seed_q   <= seed_i;
                  pos_q    <= seed_i[POS_W-1:0];
                  long_q   <= seed_i[POS_W];
                  idx_q    <= '0;
                  placed_q <= '0;
                  state_q  <= PL_TEST;
               end
            end
            PL_TEST: begin
               if (fits) begin
                  placed_q <= placed_q | cand;
                  if (last) begin
                     state_q <= PL_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q  <= idx_inc;
                     pos_q  <= nxt_field[POS_W-1:0];
                     long_q <= nxt_field[POS_W];
                  end
               end else begin
                  pos_q <= pos_q + POS_W'(1);
               end
            end
            default: state_q <= PL_IDLE;
         endcase
      end
   end

   assign mask_o = placed_q;
   assign done_o = done_q;
endmodule

// File: rtl/bomb_placer_chk.sv
module bomb_placer_chk #(
   parameter int unsigned CELLS = 16,
   parameter int unsigned BOMBS = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             busy_i,
   input logic [CELLS-1:0] mask_i,
   input logic             done_i
);
   localparam int unsigned LIMIT = BOMBS * CELLS;

   logic [CELLS-1:0] up1;
   logic [CELLS-1:0] up2;
   logic [15:0]      run_cnt;

   assign up1 = {mask_i[CELLS-2:0], mask_i[CELLS-1]};
   assign up2 = {up1[CELLS-2:0], up1[CELLS-1]};

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     run_cnt <= '0;
      else if (busy_i) run_cnt <= run_cnt + 16'd1;
      else             run_cnt <= '0;
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i); // R6
   AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> !busy_i); // R6
   AST_MASK_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> ((mask_i & $past(mask_i)) == $past(mask_i))); // R5
   AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && !start_i) |=> $stable(mask_i)); // R10
   AST_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_i & up1 & up2) == '0); // R8
   AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> ($countones(mask_i) >= BOMBS && $countones(mask_i) <= 2 * BOMBS)); // R12
   AST_LATENCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(run_cnt) <= LIMIT); // R9
endmodule

bind bomb_placer bomb_placer_chk #(.CELLS(CELLS), .BOMBS(BOMBS)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .start_i(start_i),
   .busy_i (busy),
   .mask_i (mask_o),
   .done_i (done_o)
);

// File: tb/bomb_placer_test.sv
`timescale 1ns/1ps
module bomb_placer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [14:0] seed = '0;
   logic [15:0] mask;
   logic        done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #2.5 clk = ~clk;

   bomb_placer uut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .start_i(start),
      .seed_i (seed),
      .mask_o (mask),
      .done_o (done)
   );

   // behavioural reference model
   int m_cell [16];
   int m_busy, m_idx, m_pos, m_len, m_done;
   int m_seed;

   function automatic int m_mask();
      int v = 0;
      for (int c = 0; c < 16; c++) if (m_cell[c] != 0) v = v | (1 << c);
      return v;
   endfunction

   function automatic bit m_fits();
      for (int j = 0; j <= m_len; j++) begin
         int c = (m_pos + j) % 16;
         if (m_cell[(c + 15) % 16] != 0 || m_cell[c] != 0 || m_cell[(c + 1) % 16] != 0)
            return 0;
      end
      return 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 16; c++) m_cell[c] = 0;
         m_busy = 0; m_idx = 0; m_pos = 0; m_len = 0; m_done = 0; m_seed = 0;
      end else begin
         m_done = 0;
         if (m_busy == 0) begin
            if (start) begin
               for (int c = 0; c < 16; c++) m_cell[c] = 0;
               m_seed = int'(seed);
               m_idx = 0;
               m_pos = m_seed % 16;
               m_len = (m_seed / 16) % 2;
               m_busy = 1;
            end
         end else if (m_fits()) begin
            for (int j = 0; j <= m_len; j++) m_cell[(m_pos + j) % 16] = 1;
            if (m_idx == 2) begin
               m_busy = 0;
               m_done = 1;
            end else begin
               m_idx = m_idx + 1;
               m_pos = (m_seed >> (5 * m_idx)) % 16;
               m_len = ((m_seed >> (5 * m_idx)) / 16) % 2;
            end
         end else begin
            m_pos = (m_pos + 1) % 16;
         end
      end
   end

   // per-cycle comparison (R2 R4 R5 R6 R7 R10 through the model)
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         checks++;
         if (int'(mask) != m_mask() || int'(done) != m_done) begin
            fails++;
            $display("FAIL R4 model compare at %0t: mask=%h done=%0d expected mask=%h done=%0d",
                     $time, mask, done, m_mask(), m_done);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // runs one placement; optionally injects a stray start two cycles in
   task automatic run(input logic [14:0] s, input bit stray, output int cyc, output int fin);
      @(negedge clk);
      seed = s;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seed = ~s;
      cyc = 1;
      if (done) fin = int'(mask);
      while (!done && cyc < 100) begin
         if (stray && cyc == 2) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      fin = int'(mask);
   endtask

   initial begin
      int cyc, fin;
      repeat (3) @(negedge clk);
      check("R1 reset mask", int'(mask), 0);
      check("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first cycle mask", int'(mask), 0);

      // R11 R2: no collisions, bombs at 3, 8..9, 12
      run(15'h3303, 0, cyc, fin);
      check("R11 latency", cyc, 4);
      check("R2 mask", fin, 16'h1308);
      @(negedge clk);
      check("R6 done drops", int'(done), 0);

      // R4: all-zero seed walks to cells 0, 2, 4
      run(15'h0000, 0, cyc, fin);
      check("R4 mask", fin, 16'h0015);
      check("R4 latency", cyc, 10);

      // R2 R4: all ones, two-cell bombs, wrap 15->0
      run(15'h7FFF, 0, cyc, fin);
      check("R2 wrap mask", fin, 16'h806D);
      check("R4 wrap latency", cyc, 13);

      // R10: idle with seed changes, no start
      for (int i = 0; i < 5; i++) begin
         seed = 15'(i * 977);
         @(negedge clk);
      end
      check("R10 idle frozen", int'(mask), 16'h806D);

      // R7: stray start ignored during a run
      run(15'h0000, 1, cyc, fin);
      check("R7 mask", fin, 16'h0015);
      check("R7 latency", cyc, 10);

      // R3: new start clears the previous mask at its edge
      @(negedge clk);
      seed = 15'h3303;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R3 cleared", int'(mask), 0);
      repeat (4) @(negedge clk);

      // R5 R8 R9 R12: random seeds, model checks each cycle
      for (int i = 0; i < 40; i++) begin
         run(15'($urandom), 0, cyc, fin);
         checks++;
         if (cyc > 49) begin
            fails++;
            $display("FAIL R9 latency: actual=%0d expected<=49", cyc);
         end
      end

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule